// File: doc/BRIEF.md
# DMA Ready Source Selector

The block picks one of eight peripheral request lines and presents it as the single ready input of a DMA controller. Software chooses the source by writing a byte to an 8-bit I/O port, and only the low three bits of that byte are used. Every source level is captured into a live request vector on each clock. Because the vector always holds every source, a new selection reaches the ready output on the clock edge of the write. There is no wait for the new source to toggle.

The floppy controller's data-request line has the opposite polarity to the DMA ready input. It is inverted on its way into the vector. A status byte reports the floppy interrupt and the floppy data request in their raw sense, so software can poll the controller without going through the DMA path.

Top module: `dma_rdy_mux`

## Requirements
- R1: While rst_ni is low, dma_rdy_o is 0 and status_o is 8'h00. The selection and the request vector are cleared, so the floppy source (index 0) is selected.
- R2: The selection is sel_wdata_i[2:0], loaded on a clock edge where sel_we_i is 1. Bits 7:3 of the written byte have no effect on dma_rdy_o.
- R3: While sel_we_i is 0, the selection keeps its last written value.
- R4: Source index 0 is the floppy data request. It is inverted: with index 0 selected, dma_rdy_o = NOT src_i[0].
- R5: Source indices 1 to 7 are serial A, serial B, hard-disk bus, serial C, serial D, external ready 1 and external ready 2, in that order. They are passed without inversion: with index k selected, dma_rdy_o = src_i[k].
- R6: A level change on the selected source reaches dma_rdy_o after the next rising clock edge and not before it.
- R7: When the selection is rewritten, dma_rdy_o takes the stored level of the newly selected source on the edge of the write. It does not wait for that source to change.
- R8: status_o[6] is the floppy interrupt fdc_irq_i and status_o[7] is the uninverted src_i[0], both as sampled at the last rising edge.
- R9: status_o[5:0] always read as zero.
- R10: If a selection write and a level change on the newly selected source occur before the same edge, dma_rdy_o after that edge shows the new source's new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Write strobe for the selection port |
| sel_wdata_i | input | 8 | Byte written to the selection port |
| src_i | input | 8 | Request levels; bit k is source index k, bit 0 is the raw floppy data request |
| fdc_irq_i | input | 1 | Floppy controller interrupt |
| dma_rdy_o | output | 1 | Ready to the DMA controller |
| status_o | output | 8 | Status byte: bit 7 floppy request, bit 6 floppy interrupt, bits 5:0 zero |

## Verification
The bench builds the block with its default parameters: eight sources, an 8-bit port, and the inversion applied only to index 0. With these values every source index, including the inverted one, is reachable through a 3-bit field. Random port bytes with random upper bits test that bits 7:3 are ignored. Random request vectors combined with reselections test that the output follows the stored level of the new source, including when the write and the level change arrive in the same cycle.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int unsigned SRC_N    = 8;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned FDC_IDX  = 0;
  localparam int unsigned IRQ_BIT  = 6;
  localparam int unsigned DRQ_BIT  = 7;
  localparam logic [SRC_N-1:0] INV_MASK = 8'h01;
endpackage

// File: rtl/dmx_sel_reg.sv
module dmx_sel_reg #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [SEL_W-1:0]  sel_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (we_i) sel_q <= wdata_i[SEL_W-1:0];
  end

  assign sel_o = sel_q;

  assert_sel_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sel_q == $past(wdata_i[SEL_W-1:0]));
  assert_sel_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(sel_q));
endmodule

// File: rtl/dmx_src_vec.sv
module dmx_src_vec #(
  parameter int unsigned      SRC_N    = 8,
  parameter logic [SRC_N-1:0] INV_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_i,
  output logic [SRC_N-1:0] vec_o
);
  logic [SRC_N-1:0] vec_q;

  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    logic lvl;
    if (INV_MASK[k]) begin : g_inv
      assign lvl = ~src_i[k];
    end else begin : g_thru
      assign lvl = src_i[k];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_q[k] <= 1'b0;
      else         vec_q[k] <= lvl;
    end
  end

  assign vec_o = vec_q;

  // R4/R5: every stored bit follows its source with the fixed polarity
  assert_vec_track_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vec_q ^ INV_MASK) == $past(src_i));
endmodule

// File: rtl/dmx_status.sv
module dmx_status #(
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned IRQ_BIT = 6,
  parameter int unsigned DRQ_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              drq_i,
  output logic [PORT_W-1:0] status_o
);
  logic irq_q, drq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      drq_q <= 1'b0;
    end else begin
      irq_q <= irq_i;
      drq_q <= drq_i;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[IRQ_BIT] = irq_q;
    status_o[DRQ_BIT] = drq_q;
  end

  assert_stat_drq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[DRQ_BIT] == $past(drq_i));
  assert_stat_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[IRQ_BIT] == $past(irq_i));
  assert_stat_pad_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o) <= 2);
endmodule

// File: rtl/dma_rdy_mux.sv
module dma_rdy_mux
  import dmx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic [PORT_W-1:0] sel_wdata_i,
  input  logic [SRC_N-1:0]  src_i,
  input  logic              fdc_irq_i,
  output logic              dma_rdy_o,
  output logic [PORT_W-1:0] status_o
);
  localparam int unsigned SEL_W = $clog2(SRC_N);

  logic [SEL_W-1:0] sel;
  logic [SRC_N-1:0] vec;

  dmx_sel_reg #(.PORT_W(PORT_W), .SEL_W(SEL_W)) i_sel (
    .clk_i, .rst_ni, .we_i(sel_we_i), .wdata_i(sel_wdata_i), .sel_o(sel));

  dmx_src_vec #(.SRC_N(SRC_N), .INV_MASK(INV_MASK)) i_vec (
    .clk_i, .rst_ni, .src_i, .vec_o(vec));

  dmx_status #(.PORT_W(PORT_W), .IRQ_BIT(IRQ_BIT), .DRQ_BIT(DRQ_BIT)) i_stat (
    .clk_i, .rst_ni, .irq_i(fdc_irq_i), .drq_i(src_i[FDC_IDX]), .status_o);

  assign dma_rdy_o = vec[sel];

  always_comb begin
    if (!rst_ni) assert_rst_R1: assert (dma_rdy_o == 1'b0 && status_o == '0);
  end

  assert_fdc_inv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && sel_wdata_i[SEL_W-1:0] == SEL_W'(FDC_IDX)) |=> dma_rdy_o == !$past(src_i[FDC_IDX]));
  assert_reselect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_we_i && sel_wdata_i[SEL_W-1:0] != SEL_W'(FDC_IDX))
      |=> dma_rdy_o == $past(src_i[sel_wdata_i[SEL_W-1:0]]));
  assert_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_we_i && sel != SEL_W'(FDC_IDX)) |=> dma_rdy_o == $past(src_i[sel]));
endmodule

// File: tb/test_dma_rdy_mux.sv
module test_dma_rdy_mux;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_we_i = 1'b0;
  logic [7:0] sel_wdata_i = '0;
  logic [7:0] src_i = '0;
  logic       fdc_irq_i = 1'b0;
  logic       dma_rdy_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] cur_sel = '0;

  always #10 clk_i = ~clk_i;

  dma_rdy_mux i_dma_rdy_mux (.*);

  function automatic logic exp_rdy(logic [2:0] s, logic [7:0] v);
    return (s == 3'd0) ? ~v[0] : v[s];
  endfunction

  task automatic chk_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rdy act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic chk_stat(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s status act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, apply one rising edge, return at the next negedge
  task automatic cycle(logic we, logic [7:0] wd, logic [7:0] src, logic irq);
    sel_we_i = we; sel_wdata_i = wd; src_i = src; fdc_irq_i = irq;
    if (we) cur_sel = wd[2:0];
    @(posedge clk_i);
    @(negedge clk_i);
    sel_we_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    src_i = 8'hFF; fdc_irq_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_bit("R1", dma_rdy_o, 1'b0);
    chk_stat("R1", status_o, 8'h00);
    rst_ni = 1'b1;

    // R4: floppy selected after reset, inverted
    cycle(1'b0, 8'h00, 8'h00, 1'b0);
    chk_bit("R4", dma_rdy_o, 1'b1);
    cycle(1'b0, 8'h00, 8'h01, 1'b0);
    chk_bit("R4", dma_rdy_o, 1'b0);
    chk_stat("R8", status_o, 8'h80);

    // R5: each non-inverted index
    for (int k = 1; k < 8; k++) begin
      cycle(1'b1, 8'(k), 8'(1 << k), 1'b0);
      chk_bit("R5", dma_rdy_o, 1'b1);
      cycle(1'b0, 8'h00, ~8'(1 << k), 1'b0);
      chk_bit("R5", dma_rdy_o, 1'b0);
    end

    // R2: upper bits ignored (8'hFA selects 2)
    cycle(1'b0, 8'h00, 8'h04, 1'b0);
    cycle(1'b1, 8'hFA, 8'h04, 1'b0);
    chk_bit("R2", dma_rdy_o, 1'b1);

    // R6: change not visible before the edge, visible after
    src_i = 8'h00;
    #1 chk_bit("R6", dma_rdy_o, 1'b1);
    cycle(1'b0, 8'h00, 8'h00, 1'b0);
    chk_bit("R6", dma_rdy_o, 1'b0);

    // R7: reselect takes stored level without source toggling
    cycle(1'b0, 8'h00, 8'h20, 1'b0);
    cycle(1'b1, 8'h05, 8'h20, 1'b0);
    chk_bit("R7", dma_rdy_o, 1'b1);

    // R10: write and level change in the same cycle
    cycle(1'b1, 8'h83, 8'h08, 1'b0);
    chk_bit("R10", dma_rdy_o, 1'b1);

    // R3: hold selection while sources vary
    cycle(1'b0, 8'h06, 8'hF7, 1'b0);
    chk_bit("R3", dma_rdy_o, 1'b0);

    // R8/R9: status fields
    cycle(1'b0, 8'h00, 8'h00, 1'b1);
    chk_stat("R8", status_o, 8'h40);
    cycle(1'b0, 8'h00, 8'hFF, 1'b1);
    chk_stat("R9", status_o, 8'hC0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic       we;
      logic [7:0] wd, sv;
      logic       irq;
      we  = ($urandom % 3) == 0;
      wd  = 8'($urandom);
      sv  = 8'($urandom);
      irq = 1'($urandom);
      cycle(we, wd, sv, irq);
      chk_bit(we ? "R7" : "R6", dma_rdy_o, exp_rdy(cur_sel, sv));
      chk_stat("R8", status_o, {sv[0], irq, 6'b0});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule